// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns software-issued interrupt commands into per-processor pending state. It holds a pending bit for each pair of a software interrupt number (16 numbers) and a processor port (up to 8 ports; by default 6 are built). A command word written by one processor names an interrupt number and a routing mode. The mode picks the destinations: an explicit list of ports, every built port except the sender, the sender alone, or nobody.

Software can also set and clear pending bits directly, one byte per interrupt number. Each bit of that byte stands for one processor port. A read port returns the same byte view of the current pending state. All updates are registered. Every bit touched by a write changes on the same clock edge. A clear always overrides a simultaneous set of the same bit.

Top module: `sgi_dispatch`

## Requirements
- R1: While `rst` is high at a rising edge, every pending bit is cleared; after reset, every byte read returns 0.
- R2: Command word layout: bits [3:0] give the interrupt number, bits [23:16] the port list, and bits [25:24] the routing mode. With mode 0, one edge after `cmd_we` the number becomes pending on every port whose list bit is 1.
- R3: With mode 1, the number becomes pending on every built port except `cmd_src`. If `cmd_src` names a port that is not built, it becomes pending on all built ports.
- R4: With mode 2, the number becomes pending only on port `cmd_src`. If that port is not built, nothing changes.
- R5: With mode 3, the command changes no pending bit.
- R6: Command bits [15:4] and [31:26] have no effect on the result.
- R7: List bits, set-byte bits and sender numbers that refer to ports at or above NUM_CPUS are ignored. Read bits for such ports are 0.
- R8: A set-byte write with `set_we` to number `set_sel` makes bit k pending for port k where `set_bits[k]` is 1. A 0 bit leaves that state unchanged.
- R9: A clear-byte write with `clr_we` to number `clr_sel` removes pending state for port k where `clr_bits[k]` is 1. A 0 bit leaves that state unchanged.
- R10: `rd_bits[k]` shows the pending state of number `rd_sel` on port k, combinationally. `pend_o[k*NUM_SGI+s]` is the pending bit of number s on port k.
- R11: When a clear and a set (by command or set byte) hit the same bit in one cycle, the bit ends cleared. Untouched bits in the same cycle still set.
- R12: A pending bit never falls except through reset or a clear write naming it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word (number, list, mode) |
| cmd_src | input | 3 | Port number of the processor issuing the command |
| set_we | input | 1 | Set-byte write strobe |
| set_sel | input | 4 | Interrupt number addressed by the set byte |
| set_bits | input | 8 | Per-port set mask |
| clr_we | input | 1 | Clear-byte write strobe |
| clr_sel | input | 4 | Interrupt number addressed by the clear byte |
| clr_bits | input | 8 | Per-port clear mask |
| rd_sel | input | 4 | Interrupt number to read |
| rd_bits | output | 8 | Per-port pending byte for `rd_sel` |
| pend_o | output | NUM_CPUS*NUM_SGI | All pending bits, port-major |

## Verification
Several properties are checked on every cycle. A bit never falls unless a clear named it, and a clear beats any set landing in the same cycle. A reserved-mode command alone leaves the state frozen, a self-targeted command lands on its sender, and read bits for ports that are not built stay zero. The exact destination set of each routing mode needs the bench's scenarios to show it. So do the effect of reserved command bits, the ignoring of zero mask bits, and the reset contents.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int MAX_CPUS = 8;
    localparam int ID_W     = 4;

    typedef enum logic [1:0] {
        RT_LIST   = 2'd0,
        RT_OTHERS = 2'd1,
        RT_SELF   = 2'd2,
        RT_NONE   = 2'd3
    } route_e;

    typedef struct packed {
        logic [5:0]      rsv_hi;
        route_e          mode;
        logic [7:0]      plist;
        logic [11:0]     rsv_lo;
        logic [ID_W-1:0] num;
    } sgi_cmd_t;

    // Destination ports for one command, before masking to built ports.
    function automatic logic [MAX_CPUS-1:0] route_mask(
        input route_e          mode,
        input logic [7:0]      plist,
        input logic [2:0]      src
    );
        logic [MAX_CPUS-1:0] src_oh;
        src_oh = MAX_CPUS'(1) << src;
        case (mode)
            RT_LIST:   route_mask = plist;
            RT_OTHERS: route_mask = ~src_oh;
            RT_SELF:   route_mask = src_oh;
            default:   route_mask = '0;
        endcase
    endfunction

endpackage

// File: rtl/sgi_cmd_decode.sv
module sgi_cmd_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 6,
    parameter int NUM_SGI  = 16
) (
    input  logic                         cmd_we,
    input  logic [31:0]                  cmd_word,
    input  logic [2:0]                   cmd_src,
    output logic [NUM_CPUS*NUM_SGI-1:0]  hit_o
);
    localparam logic [MAX_CPUS-1:0] BUILT = MAX_CPUS'((9'd1 << NUM_CPUS) - 9'd1);

    sgi_cmd_t            cmd;
    logic [MAX_CPUS-1:0] dest;
    logic                num_ok;

    always_comb begin
        cmd    = sgi_cmd_t'(cmd_word);
        dest   = route_mask(cmd.mode, cmd.plist, cmd_src) & BUILT;
        num_ok = int'(cmd.num) < NUM_SGI;
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SGI; s++) begin : g_num
            assign hit_o[c*NUM_SGI+s] = cmd_we && num_ok && dest[c]
                                        && (cmd.num == ID_W'(s));
        end
    end
endmodule

// File: rtl/sgi_byte_write.sv
module sgi_byte_write
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 6,
    parameter int NUM_SGI  = 16
) (
    input  logic                         we,
    input  logic [ID_W-1:0]              sel,
    input  logic [MAX_CPUS-1:0]          bits,
    output logic [NUM_CPUS*NUM_SGI-1:0]  mask_o
);
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SGI; s++) begin : g_num
            assign mask_o[c*NUM_SGI+s] = we && (sel == ID_W'(s)) && bits[c];
        end
    end
endmodule

// File: rtl/sgi_pend_row.sv
module sgi_pend_row #(
    parameter int NUM_SGI = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SGI-1:0] set_i,
    input  logic [NUM_SGI-1:0] clr_i,
    output logic [NUM_SGI-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= (q_o | set_i) & ~clr_i;
    end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 6,
    parameter int NUM_SGI  = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_we,
    input  logic [31:0]                  cmd_word,
    input  logic [2:0]                   cmd_src,
    input  logic                         set_we,
    input  logic [3:0]                   set_sel,
    input  logic [7:0]                   set_bits,
    input  logic                         clr_we,
    input  logic [3:0]                   clr_sel,
    input  logic [7:0]                   clr_bits,
    input  logic [3:0]                   rd_sel,
    output logic [7:0]                   rd_bits,
    output logic [NUM_CPUS*NUM_SGI-1:0]  pend_o
);
    localparam int NBITS = NUM_CPUS * NUM_SGI;

    logic [NBITS-1:0] cmd_hit, byte_set, byte_clr, set_all;

    sgi_cmd_decode #(.NUM_CPUS(NUM_CPUS), .NUM_SGI(NUM_SGI)) u_dec (
        .cmd_we   (cmd_we),
        .cmd_word (cmd_word),
        .cmd_src  (cmd_src),
        .hit_o    (cmd_hit)
    );

    sgi_byte_write #(.NUM_CPUS(NUM_CPUS), .NUM_SGI(NUM_SGI)) u_setw (
        .we     (set_we),
        .sel    (set_sel),
        .bits   (set_bits),
        .mask_o (byte_set)
    );

    sgi_byte_write #(.NUM_CPUS(NUM_CPUS), .NUM_SGI(NUM_SGI)) u_clrw (
        .we     (clr_we),
        .sel    (clr_sel),
        .bits   (clr_bits),
        .mask_o (byte_clr)
    );

    assign set_all = cmd_hit | byte_set;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_row
        sgi_pend_row #(.NUM_SGI(NUM_SGI)) u_row (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_all[c*NUM_SGI +: NUM_SGI]),
            .clr_i (byte_clr[c*NUM_SGI +: NUM_SGI]),
            .q_o   (pend_o[c*NUM_SGI +: NUM_SGI])
        );
    end

    always_comb begin
        rd_bits = '0;
        if (int'(rd_sel) < NUM_SGI) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                rd_bits[c] = pend_o[c*NUM_SGI + int'(rd_sel)];
            end
        end
    end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
    parameter int NUM_CPUS = 6,
    parameter int NUM_SGI  = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         cmd_we,
    input logic [31:0]                  cmd_word,
    input logic [2:0]                   cmd_src,
    input logic                         set_we,
    input logic                         clr_we,
    input logic [3:0]                   clr_sel,
    input logic [7:0]                   clr_bits,
    input logic [7:0]                   rd_bits,
    input logic [NUM_CPUS*NUM_SGI-1:0]  pend_o
);
    localparam int NBITS = NUM_CPUS * NUM_SGI;

    logic [NBITS-1:0] clr_mask;
    logic [7:0]       self_idx;
    logic             self_cmd;
    logic             rst_q;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
        for (genvar s = 0; s < NUM_SGI; s++) begin : g_s
            assign clr_mask[c*NUM_SGI+s] = clr_we && (clr_sel == 4'(s)) && clr_bits[c];
        end
    end

    assign self_cmd = cmd_we && (cmd_word[25:24] == 2'd2) && !clr_we
                      && (int'(cmd_src) < NUM_CPUS) && (int'(cmd_word[3:0]) < NUM_SGI);
    assign self_idx = 8'(int'(cmd_src) * NUM_SGI + int'(cmd_word[3:0]));

    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_q) begin
            after_reset_clear_chk: assert (pend_o == '0);
        end
    end

    // R12
    no_silent_fall_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_o) & ~pend_o & ~$past(clr_mask)) == '0));

    // R11
    clear_beats_set_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((pend_o & $past(clr_mask)) == '0));

    // R5
    reserved_mode_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_word[25:24] == 2'd3 && !set_we && !clr_we) |=> $stable(pend_o));

    // R4
    self_target_lands_chk: assert property (@(posedge clk) disable iff (rst)
        self_cmd |=> pend_o[$past(self_idx)]);

    // R7
    unbuilt_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((16'(rd_bits) >> NUM_CPUS) == 16'd0));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPUS(NUM_CPUS), .NUM_SGI(NUM_SGI)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_we   (cmd_we),
    .cmd_word (cmd_word),
    .cmd_src  (cmd_src),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .clr_sel  (clr_sel),
    .clr_bits (clr_bits),
    .rd_bits  (rd_bits),
    .pend_o   (pend_o)
);

// File: tb/test_sgi_dispatch.sv
`timescale 1ns/100ps
module test_sgi_dispatch;
    localparam int NUM_CPUS = 6;
    localparam int NUM_SGI  = 16;
    localparam int NV       = 10;

    // {command word, sender, expected byte, requirement number}
    localparam logic [46:0] VEC [NV] = '{
        {32'h0005_0003, 3'd0, 8'h05, 4'd2},  // R2 list 0x05, number 3
        {32'h00FF_000F, 3'd2, 8'h3F, 4'd7},  // R7 list bits 6,7 dropped
        {32'h00C0_0000, 3'd1, 8'h00, 4'd7},  // R7 only unbuilt ports listed
        {32'h0100_0007, 3'd2, 8'h3B, 4'd3},  // R3 all but port 2
        {32'h013F_0001, 3'd0, 8'h3E, 4'd3},  // R3 list ignored, all but port 0
        {32'h0201_0009, 3'd5, 8'h20, 4'd4},  // R4 sender only
        {32'h0200_0009, 3'd7, 8'h00, 4'd4},  // R4 unbuilt sender: nothing
        {32'h03FF_0004, 3'd1, 8'h00, 4'd5},  // R5 reserved mode
        {32'hFC12_FFF6, 3'd3, 8'h12, 4'd6},  // R6 reserved bits set
        {32'h0100_0002, 3'd6, 8'h3F, 4'd3}   // R3 unbuilt sender: all built
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [2:0]  cmd_src = '0;
    logic        set_we = 1'b0;
    logic [3:0]  set_sel = '0;
    logic [7:0]  set_bits = '0;
    logic        clr_we = 1'b0;
    logic [3:0]  clr_sel = '0;
    logic [7:0]  clr_bits = '0;
    logic [3:0]  rd_sel = '0;
    logic [7:0]  rd_bits;
    logic [NUM_CPUS*NUM_SGI-1:0] pend_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    sgi_dispatch #(.NUM_CPUS(NUM_CPUS), .NUM_SGI(NUM_SGI)) i_sgi_dispatch (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_word(cmd_word), .cmd_src(cmd_src),
        .set_we(set_we), .set_sel(set_sel), .set_bits(set_bits),
        .clr_we(clr_we), .clr_sel(clr_sel), .clr_bits(clr_bits),
        .rd_sel(rd_sel), .rd_bits(rd_bits), .pend_o(pend_o)
    );

    task automatic check_byte(input logic [3:0] sel, input logic [7:0] exp, input string tag);
        rd_sel = sel;
        #1;
        n_chk++;
        if (rd_bits !== exp) begin
            n_bad++;
            $display("FAIL %s: byte %0d got %h expected %h", tag, sel, rd_bits, exp);
        end
    endtask

    task automatic check_bit(input int idx, input logic exp, input string tag);
        n_chk++;
        if (pend_o[idx] !== exp) begin
            n_bad++;
            $display("FAIL %s: pend_o[%0d] got %b expected %b", tag, idx, pend_o[idx], exp);
        end
    endtask

    // One-cycle pulses; the edge in between updates state.
    task automatic pulse(input logic c_we, input logic [31:0] w, input logic [2:0] src,
                         input logic s_we, input logic [3:0] ssel, input logic [7:0] sb,
                         input logic k_we, input logic [3:0] ksel, input logic [7:0] kb);
        @(negedge clk);
        cmd_we = c_we; cmd_word = w; cmd_src = src;
        set_we = s_we; set_sel = ssel; set_bits = sb;
        clr_we = k_we; clr_sel = ksel; clr_bits = kb;
        @(negedge clk);
        cmd_we = 1'b0; set_we = 1'b0; clr_we = 1'b0;
        cmd_word = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: all bytes zero after reset
        for (int s = 0; s < NUM_SGI; s++) check_byte(4'(s), 8'h00, "R1");

        // Vector table: clear byte, issue command, read byte
        for (int v = 0; v < NV; v++) begin
            logic [31:0] w;
            logic [2:0]  src;
            logic [7:0]  exp;
            logic [3:0]  req;
            {w, src, exp, req} = VEC[v];
            pulse(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, w[3:0], 8'hFF);
            pulse(1'b1, w, src, 1'b0, '0, '0, 1'b0, '0, '0);
            check_byte(w[3:0], exp, $sformatf("R%0d vec%0d", req, v));
        end

        // R8: set byte, zeros leave state, unbuilt bits dropped (R7)
        pulse(1'b0, '0, '0, 1'b1, 4'd5, 8'h0A, 1'b0, '0, '0);
        check_byte(4'd5, 8'h0A, "R8 set");
        pulse(1'b0, '0, '0, 1'b1, 4'd5, 8'h00, 1'b0, '0, '0);
        check_byte(4'd5, 8'h0A, "R8 zero-set");
        pulse(1'b0, '0, '0, 1'b1, 4'd5, 8'hC1, 1'b0, '0, '0);
        check_byte(4'd5, 8'h0B, "R7 set unbuilt");

        // R10: flat output agrees with byte view
        check_bit(0*NUM_SGI+5, 1'b1, "R10 port0");
        check_bit(2*NUM_SGI+5, 1'b0, "R10 port2");
        check_bit(3*NUM_SGI+5, 1'b1, "R10 port3");

        // R9: clear byte, zeros leave state
        pulse(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd5, 8'h02);
        check_byte(4'd5, 8'h09, "R9 clear");
        pulse(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 4'd5, 8'h00);
        check_byte(4'd5, 8'h09, "R9 zero-clear");

        // R11: command and clear on the same number in one cycle
        pulse(1'b1, 32'h003F_0008, 3'd0, 1'b0, '0, '0, 1'b1, 4'd8, 8'h05);
        check_byte(4'd8, 8'h3A, "R11 cmd vs clear");
        // R11: set byte and clear byte in one cycle
        pulse(1'b0, '0, '0, 1'b1, 4'd10, 8'h0F, 1'b1, 4'd10, 8'h03);
        check_byte(4'd10, 8'h0C, "R11 set vs clear");

        // R12: state holds across idle cycles
        repeat (20) @(negedge clk);
        check_byte(4'd5, 8'h09, "R12 hold 5");
        check_byte(4'd8, 8'h3A, "R12 hold 8");

        // R1: reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_byte(4'd8, 8'h00, "R1 re-reset");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule